// File: doc/BRIEF.md
# Diagnostic Beep Pattern Generator

This block turns an 8-bit diagnostic code into an audible pattern on a speaker-enable line. A start strobe, accepted only while the block is idle, captures the code together with a pattern-select input. In the coded mode the code is cut into four 2-bit fields. The field held in bits 7:6 plays first and the field in bits 1:0 plays last. Each field plays as a burst of short tones whose count is the field value plus one.

In the alternate mode the code is ignored. The block plays a fixed pattern meant for recoverable faults: one long tone, a group gap, then two short tones. Every tone length and every gap length is a cycle count set by a parameter. The speaker output is only an on/off enable, so the tone frequency is produced elsewhere. A busy flag covers the whole pattern, and a one-cycle done pulse follows the trailing gap.

Top module: `beep_pattern_gen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves spk_en, busy and done low, and no pattern resumes afterwards.
- R2: When start is high at an edge while busy is low, spk_en and busy are both high in the cycle that follows that edge.
- R3: In coded mode (alt_sel=0 at start) four groups play in order err_code[7:6], [5:4], [3:2], [1:0]. The number of tones in each group is the field value plus one, so 0x1A plays 1-2-3-3.
- R4: Every short tone holds spk_en high for exactly SHORT_CYC cycles. Tones within one group are separated by exactly BEAT_GAP_CYC low cycles.
- R5: Consecutive groups are separated by exactly GROUP_GAP_CYC low cycles, and the same gap follows the last tone. GROUP_GAP_CYC is meant to be clearly larger than BEAT_GAP_CYC.
- R6: In alternate mode (alt_sel=1 at start) the pattern is one tone of LONG_CYC cycles, then a gap of GROUP_GAP_CYC, then two short tones separated by BEAT_GAP_CYC. The value of err_code has no effect.
- R7: A start strobe that arrives while busy is high is ignored. err_code and alt_sel are captured only when a start is accepted, so changes to them during a pattern have no effect.
- R8: done is high for exactly one cycle, in the cycle right after the trailing gap. In that cycle busy is already low and a new start can be accepted.
- R9: busy stays high from the first tone to the end of the trailing gap, and spk_en is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, honoured only while idle |
| alt_sel | input | 1 | 1 selects the fixed long-short-short pattern |
| err_code | input | 8 | Diagnostic code, captured when a start is accepted |
| spk_en | output | 1 | Speaker enable, high during each tone |
| busy | output | 1 | High while a pattern is playing |
| done | output | 1 | One-cycle pulse at the end of a pattern |

## Verification
The bench builds the block with SHORT_CYC=3, LONG_CYC=9, BEAT_GAP_CYC=2 and GROUP_GAP_CYC=6. Each of the four lengths is then distinct and a whole pattern lasts under 150 cycles. This makes it cheap to play all 256 codes and rebuild every group count from the measured run lengths of spk_en. Because the long tone and the two gap kinds have different lengths, a tone or gap of the wrong kind shows up as a wrong length.

// File: rtl/beep_pkg.sv
package beep_pkg;

    localparam int CODE_W  = 8;
    localparam int FIELD_W = 2;
    localparam int GROUPS  = CODE_W / FIELD_W;
    localparam int GRP_W   = $clog2(GROUPS);
    localparam int BEEP_W  = FIELD_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TONE = 2'd1,
        ST_GAP  = 2'd2
    } beep_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              alt;
    } beep_req_t;

    // Tone count of a group: coded mode plays field+1, most significant field first.
    function automatic logic [BEEP_W-1:0] group_beeps(input logic [CODE_W-1:0] code,
                                                      input logic alt,
                                                      input logic [GRP_W-1:0] idx);
        logic [FIELD_W-1:0] fld;
        if (alt)
            return (idx == '0) ? BEEP_W'(1) : BEEP_W'(2);
        fld = code[(CODE_W-1 - FIELD_W*int'(idx)) -: FIELD_W];
        return BEEP_W'(fld) + BEEP_W'(1);
    endfunction

    function automatic logic [GRP_W-1:0] last_group(input logic alt);
        return alt ? GRP_W'(1) : GRP_W'(GROUPS-1);
    endfunction

endpackage

// File: rtl/beep_timer.sv
module beep_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R4: a loaded count only ever runs down toward zero
    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/beep_seq.sv
module beep_seq
    import beep_pkg::*;
#(
    parameter int SHORT_CYC     = 3,
    parameter int LONG_CYC      = 9,
    parameter int BEAT_GAP_CYC  = 2,
    parameter int GROUP_GAP_CYC = 6,
    parameter int CW            = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              alt_sel,
    input  logic [CODE_W-1:0] err_code,
    input  logic              expired,
    output logic              tmr_load,
    output logic [CW-1:0]     tmr_val,
    output logic              spk_en,
    output logic              busy,
    output logic              done
);
    beep_state_e      state, state_d;
    beep_req_t        req_q, req_d;
    logic [GRP_W-1:0] grp, grp_d;
    logic [BEEP_W-1:0] rem, rem_d;
    logic             done_q, done_d;
    logic             beat_last, grp_final;

    assign beat_last = (rem == BEEP_W'(1));
    assign grp_final = (grp == last_group(req_q.alt));

    always_comb begin
        state_d  = state;
        req_d    = req_q;
        grp_d    = grp;
        rem_d    = rem;
        done_d   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: if (start) begin
                req_d    = '{code: err_code, alt: alt_sel};
                grp_d    = '0;
                rem_d    = group_beeps(err_code, alt_sel, '0);
                state_d  = ST_TONE;
                tmr_load = 1'b1;
                tmr_val  = alt_sel ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
            end
            ST_TONE: if (expired) begin
                state_d  = ST_GAP;
                tmr_load = 1'b1;
                tmr_val  = beat_last ? CW'(GROUP_GAP_CYC - 1) : CW'(BEAT_GAP_CYC - 1);
            end
            ST_GAP: if (expired) begin
                if (beat_last && grp_final) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else begin
                    state_d  = ST_TONE;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(SHORT_CYC - 1);
                    if (beat_last) begin
                        grp_d = grp + 1'b1;
                        rem_d = group_beeps(req_q.code, req_q.alt, grp + 1'b1);
                    end else begin
                        rem_d = rem - 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            req_q  <= '0;
            grp    <= '0;
            rem    <= '0;
            done_q <= 1'b0;
        end else begin
            state  <= state_d;
            req_q  <= req_d;
            grp    <= grp_d;
            rem    <= rem_d;
            done_q <= done_d;
        end
    end

    assign spk_en = (state == ST_TONE);
    assign busy   = (state != ST_IDLE);
    assign done   = done_q;

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!spk_en && !busy && !done));
    a_r2_start_plays: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (spk_en && busy));
    a_r7_capture_held: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(req_q));
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r9_spk_in_busy: assert property (@(posedge clk) disable iff (rst)
        spk_en |-> busy);
    a_r3_beats_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rem >= BEEP_W'(1) && rem <= BEEP_W'(4)));

endmodule

// File: rtl/beep_pattern_gen.sv
module beep_pattern_gen
    import beep_pkg::*;
#(
    parameter int SHORT_CYC     = 20_000_000,
    parameter int LONG_CYC      = 60_000_000,
    parameter int BEAT_GAP_CYC  = 15_000_000,
    parameter int GROUP_GAP_CYC = 45_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       alt_sel,
    input  logic [7:0] err_code,
    output logic       spk_en,
    output logic       busy,
    output logic       done
);
    localparam int MAX_A   = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int MAX_B   = (BEAT_GAP_CYC > GROUP_GAP_CYC) ? BEAT_GAP_CYC : GROUP_GAP_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          expired;

    beep_seq #(
        .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC),
        .BEAT_GAP_CYC(BEAT_GAP_CYC), .GROUP_GAP_CYC(GROUP_GAP_CYC), .CW(CW)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .alt_sel(alt_sel),
        .err_code(err_code), .expired(expired), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .spk_en(spk_en), .busy(busy), .done(done)
    );

    beep_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(expired)
    );

endmodule

// File: tb/sim_beep_pattern_gen.sv
module sim_beep_pattern_gen;
    localparam int SH = 3, LG = 9, BG = 2, GG = 6;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, alt_sel = 1'b0;
    logic [7:0] err_code = 8'h00;
    logic spk_en, busy, done;
    int checks = 0, failures = 0, cyc = 0;

    int ng, gcnt[8], bad_tone, bad_gap, busy_bad, trail, first_hi, nloop;

    always #5 clk = ~clk;

    beep_pattern_gen #(.SHORT_CYC(SH), .LONG_CYC(LG), .BEAT_GAP_CYC(BG),
                       .GROUP_GAP_CYC(GG)) u0 (
        .clk(clk), .rst(rst), .start(start), .alt_sel(alt_sel), .err_code(err_code),
        .spk_en(spk_en), .busy(busy), .done(done));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Plays one pattern, measuring run lengths of spk_en; pulses start at loop step inj.
    task automatic play(input logic [7:0] c, input logic a, input int inj);
        int hi, lo, cur, ntone;
        bit fin;
        @(negedge clk);
        err_code = c; alt_sel = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        err_code = ~c; alt_sel = ~a;
        ng = 0; bad_tone = 0; bad_gap = 0; busy_bad = 0; trail = -1;
        hi = 0; lo = 0; cur = 0; ntone = 0; fin = 0; nloop = 0;
        first_hi = (spk_en && busy) ? 1 : 0;
        while (!fin && nloop < 4000) begin
            start = (nloop == inj);
            if (done) begin
                fin = 1;
                if (busy) busy_bad++;
                if (hi > 0) bad_gap++;
                trail = lo;
                if (ng < 8) gcnt[ng] = cur;
                ng++;
            end else if (spk_en) begin
                if (lo > 0) begin
                    if (lo == GG) begin
                        if (ng < 8) gcnt[ng] = cur;
                        ng++; cur = 0;
                    end else if (lo != BG) bad_gap++;
                end
                lo = 0; hi++;
                if (!busy) busy_bad++;
            end else begin
                if (hi > 0) begin
                    if (hi != ((a && ntone == 0) ? LG : SH)) bad_tone++;
                    ntone++; cur++; hi = 0;
                end
                lo++;
                if (!busy) busy_bad++;
            end
            @(negedge clk);
            nloop++;
        end
        start = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(!spk_en && !busy && !done, "R1 reset state", {spk_en, busy, done}, 0);
    endtask

    task automatic t_all_codes();
        int bad_cnt = 0, bad_t = 0, bad_g = 0, bad_tr = 0, bad_b = 0, bad_d = 0, bad_s = 0;
        for (int c = 0; c < 256; c++) begin
            bit ok;
            play(8'(c), 1'b0, -1);
            // nloop is now one past the done cycle
            bad_d += done ? 1 : 0;
            ok = (ng == 4);
            for (int g = 0; g < 4 && g < ng; g++)
                if (gcnt[g] != ((c >> (6 - 2*g)) & 3) + 1) ok = 0;
            if (!ok) begin
                bad_cnt++;
                chk(0, "R3 group counts", ng, 4);
            end
            bad_t += bad_tone; bad_g += bad_gap; bad_b += busy_bad;
            bad_tr += (trail != GG) ? 1 : 0;
            bad_s += first_hi ? 0 : 1;
        end
        chk(bad_cnt == 0, "R3 all codes decode", bad_cnt, 0);
        chk(bad_s == 0, "R2 tone starts after accept", bad_s, 0);
        chk(bad_t == 0, "R4 short tone length", bad_t, 0);
        chk(bad_g == 0, "R4 R5 gap lengths", bad_g, 0);
        chk(bad_tr == 0, "R5 trailing gap", bad_tr, 0);
        chk(bad_b == 0, "R9 busy coverage", bad_b, 0);
        chk(bad_d == 0, "R8 done lasts one cycle", bad_d, 0);
    endtask

    task automatic t_example();
        play(8'h1A, 1'b0, -1);
        chk(ng == 4 && gcnt[0] == 1 && gcnt[1] == 2 && gcnt[2] == 3 && gcnt[3] == 3,
            "R3 code 0x1A gives 1-2-3-3", gcnt[0]*1000 + gcnt[1]*100 + gcnt[2]*10 + gcnt[3], 1233);
    endtask

    task automatic t_alt();
        play(8'hFF, 1'b1, -1);
        chk(ng == 2 && gcnt[0] == 1 && gcnt[1] == 2, "R6 long-short-short groups",
            ng*100 + gcnt[0]*10 + gcnt[1], 212);
        chk(bad_tone == 0, "R6 long then short lengths", bad_tone, 0);
        chk(bad_gap == 0 && trail == GG, "R6 gaps", trail, GG);
        play(8'h00, 1'b1, -1);
        chk(ng == 2 && gcnt[0] == 1 && gcnt[1] == 2, "R6 code ignored in alternate",
            ng*100 + gcnt[0]*10 + gcnt[1], 212);
    endtask

    task automatic t_busy_ignore();
        // inputs are inverted after acceptance and a start arrives mid pattern
        play(8'h1B, 1'b0, 5);
        chk(ng == 4 && gcnt[0] == 1 && gcnt[1] == 2 && gcnt[2] == 3 && gcnt[3] == 4,
            "R7 start while busy ignored", gcnt[0]*1000 + gcnt[1]*100 + gcnt[2]*10 + gcnt[3], 1234);
        repeat (3) @(negedge clk);
        chk(!busy && !spk_en, "R7 no pattern restarted", busy, 0);
    endtask

    task automatic t_back_to_back();
        int wait_n = 0;
        @(negedge clk);
        err_code = 8'h00; alt_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && wait_n < 200) begin @(negedge clk); wait_n++; end
        chk(done && !busy, "R8 done with busy low", {done, busy}, 2);
        start = 1'b1; err_code = 8'h40;
        @(negedge clk);
        start = 1'b0;
        chk(spk_en && busy, "R8 start accepted in done cycle", {spk_en, busy}, 3);
        wait_n = 0;
        while (!done && wait_n < 200) begin @(negedge clk); wait_n++; end
        @(negedge clk);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        err_code = 8'hFF; alt_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        chk(busy, "R9 busy during pattern", busy, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!spk_en && !busy && !done, "R1 reset mid pattern", {spk_en, busy, done}, 0);
        begin
            int seen = 0;
            repeat (30) begin @(negedge clk); seen += (spk_en || busy || done) ? 1 : 0; end
            chk(seen == 0, "R1 nothing resumes", seen, 0);
        end
    endtask

    initial begin
        t_reset();
        t_example();
        t_alt();
        t_busy_ignore();
        t_back_to_back();
        t_mid_reset();
        t_all_codes();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule